// File: doc/BRIEF.md
# Operation-Timed Integer ALU

This block is a 32-bit integer ALU that computes its result with one fixed datapath but reports completion after a number of cycles that depends on the kind of operation requested. A caller raises a start strobe for one cycle together with an opcode and two operands. The opcode selects an operation class: arithmetic, bitwise logic, shift or compare. The start strobe is then steered into the delay counter of that class alone. Each class has its own cycle count, set by its own parameter. The completion outputs of the four counters are OR-ed into one done pulse.

Cheap operations therefore finish early. Only shifts pay the longest wait, so the average latency follows the operation mix rather than the slowest class. The result is captured in a register when the operation is accepted and holds until the next accepted operation. A busy flag covers the whole time an operation is in flight, and a start strobe raised while busy is dropped.

Top module: `vlalu_top`

## Requirements
- R1: Opcodes are encoded in `op_i` as ADD=0, SUB=1, AND=2, OR=3, XOR=4, SLL=5, SRL=6, SRA=7, SLT=8, SLTU=9. ADD and SUB form the arithmetic class. AND, OR and XOR form the logic class. SLL, SRL and SRA form the shift class. SLT and SLTU form the compare class.
- R2: If `start_i` is high in a cycle while `busy_o` is low, `done_o` is high exactly L cycles later. L is the latency parameter of the opcode's class, with defaults of 2 for arithmetic, 1 for logic, 3 for shift and 1 for compare.
- R3: `done_o` is high for one cycle per accepted operation, and `result_o` holds that operation's result in that cycle.
- R4: ADD gives a+b and SUB gives a-b, both modulo 2^32.
- R5: AND, OR and XOR give the bitwise function of a and b.
- R6: SLL, SRL and SRA shift a by b[4:0]. SLL and SRL fill with zeros, and SRA fills with a[31].
- R7: SLT gives 1 if a<b as signed two's-complement numbers, otherwise 0. SLTU makes the same comparison on unsigned values.
- R8: `busy_o` is high from the cycle after acceptance through the done cycle, and low otherwise.
- R9: A start raised while `busy_o` is high is ignored. It does not change `result_o`, it does not move or add a done pulse, and it leaves `busy_o` low after the current operation ends.
- R10: Opcodes 10 to 15 are unused. They yield result 0 and take the logic-class latency.
- R11: After a synchronous active-low reset, `done_o` and `busy_o` are 0 and `result_o` is 0.
- R12: An accepted start triggers exactly one class delay path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe |
| op_i | input | 4 | Opcode (R1 encoding) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, or shift amount in bits 4:0 |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Registered result |

## Verification
All sixteen opcode values are swept against a grid of operand pairs. The grid holds zero, one, all ones, the signed extremes and mixed bit patterns, so that signed and unsigned comparison, wraparound in ADD and SUB, and arithmetic versus logical right shift give different answers. Every shift amount from 0 to 31 is tried on a value with its sign bit set, which exposes a wrong fill bit or a wrong amount width. The latency of each run is counted from the start cycle, so a mis-routed class shows up as a wrong cycle count even when its result is correct. Starts injected in the middle of a busy operation check that neither the result nor the done timing moves.

// File: rtl/vlalu_pkg.sv
// Package: shared opcode and class encodings for the operation-timed ALU.
// Assumes 4-bit opcodes; unused codes are treated as logic-class.
package vlalu_pkg;
    localparam int OP_W  = 4;
    localparam int CLS_N = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_SHIFT = 2'd2,
        CLS_CMP   = 2'd3
    } cls_e;

    // Map an opcode to its timing class (unused codes land in logic).
    function automatic cls_e class_of(input logic [OP_W-1:0] op);
        cls_e c;
        case (op)
            OP_ADD, OP_SUB:         c = CLS_ARITH;
            OP_SLL, OP_SRL, OP_SRA: c = CLS_SHIFT;
            OP_SLT, OP_SLTU:        c = CLS_CMP;
            default:                c = CLS_LOGIC;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/vlalu_router.sv
// Module: steers an accepted start strobe into the one delay path of
// the opcode's class. Assumes busy_i reflects any operation in flight.
module vlalu_router
    import vlalu_pkg::*;
(
    input  logic                start_i,
    input  logic                busy_i,
    input  logic [OP_W-1:0]     op_i,
    output logic [CLS_N-1:0]    fire_o
);
    cls_e cls;

    // Decode the class and raise at most one fire line.
    always_comb begin
        cls    = class_of(op_i);
        fire_o = '0;
        if (start_i && !busy_i)
            fire_o[cls] = 1'b1;
    end
endmodule

// File: rtl/vlalu_timer.sv
// Module: per-class delay counter. A fire pulse loads LAT; the counter
// counts down and done is high while it holds 1, i.e. LAT cycles after
// the fire cycle. Assumes LAT >= 1 and no fire while busy.
module vlalu_timer #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(LAT + 1) + 1;
    localparam logic [CW-1:0] LOAD = CW'(LAT);

    logic [CW-1:0] cnt;

    // Load on fire, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (fire_i)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Status decode of the counter.
    always_comb begin
        busy_o = (cnt != '0);
        done_o = (cnt == CW'(1));
    end

    // R8: the path is idle right after its done cycle.
    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R9: the router never fires a path that is still counting.
    assert_no_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> !busy_o);
endmodule

// File: rtl/vlalu_datapath.sv
// Module: combinational integer datapath shared by all classes; timing
// is chosen elsewhere. Assumes W is a power of two.
module vlalu_datapath
    import vlalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    y_o
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;

    // Evaluate the selected operation.
    always_comb begin
        sh = b_i[SHW-1:0];
        case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_SLL:  y_o = a_i << sh;
            OP_SRL:  y_o = a_i >> sh;
            OP_SRA:  y_o = W'($signed(a_i) >>> sh);
            OP_SLT:  y_o = W'($signed(a_i) < $signed(b_i));
            OP_SLTU: y_o = W'(a_i < b_i);
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/vlalu_top.sv
// Module: operation-timed ALU top. Captures the result on acceptance,
// routes the start into one class delay path and merges the paths'
// done outputs. Assumes every latency parameter is at least 1.
module vlalu_top
    import vlalu_pkg::*;
#(
    parameter int W         = 32,
    parameter int LAT_ARITH = 2,
    parameter int LAT_LOGIC = 1,
    parameter int LAT_SHIFT = 3,
    parameter int LAT_CMP   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [W-1:0]    result_o
);
    logic [CLS_N-1:0] fire;
    logic [CLS_N-1:0] t_busy;
    logic [CLS_N-1:0] t_done;
    logic [W-1:0]     y;
    logic             accept;

    vlalu_router u_router (
        .start_i (start_i),
        .busy_i  (busy_o),
        .op_i    (op_i),
        .fire_o  (fire)
    );

    vlalu_datapath #(.W(W)) u_dp (
        .op_i (op_i),
        .a_i  (a_i),
        .b_i  (b_i),
        .y_o  (y)
    );

    // One delay path per class, latency picked by index.
    for (genvar k = 0; k < CLS_N; k++) begin : g_path
        localparam int L = (k == int'(CLS_ARITH)) ? LAT_ARITH :
                           (k == int'(CLS_LOGIC)) ? LAT_LOGIC :
                           (k == int'(CLS_SHIFT)) ? LAT_SHIFT : LAT_CMP;
        vlalu_timer #(.LAT(L)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire_i (fire[k]),
            .busy_o (t_busy[k]),
            .done_o (t_done[k])
        );
    end

    // Merge path status into the block outputs.
    always_comb begin
        busy_o = |t_busy;
        done_o = |t_done;
        accept = start_i && !busy_o;
    end

    // Capture the result of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_o <= '0;
        else if (accept)
            result_o <= y;
    end

    // R12: an accepted start feeds exactly one path, a rejected one none.
    assert_single_path_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire) && (accept == (fire != '0)));
    // R8: acceptance makes the block busy on the next cycle.
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
    // R3: done lasts a single cycle.
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: the result does not move while an operation is in flight.
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(result_o));
    // R3: only one path reports done at a time.
    assert_one_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(t_done));
endmodule

// File: tb/tb_vlalu_top.sv
module tb_vlalu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vlalu_top dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    function automatic logic [31:0] exp_res(input logic [3:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b);
        logic [31:0] r;
        int s;
        s = int'(b[4:0]);
        case (op)
            4'd0: r = a + b;
            4'd1: r = a + (~b) + 32'd1;
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = a << s;
            4'd6: r = a >> s;
            4'd7: begin
                r = a >> s;
                for (int i = 0; i < 32; i++) if (a[31] && i >= 32 - s) r[i] = 1'b1;
            end
            4'd8: r = ((a[31] ^ b[31]) ? a[31] : (a < b)) ? 32'd1 : 32'd0;
            4'd9: r = (a < b) ? 32'd1 : 32'd0;
            default: r = 32'd0;
        endcase
        return r;
    endfunction

    function automatic int exp_lat(input logic [3:0] op);
        if (op <= 4'd1) return 2;
        if (op >= 4'd5 && op <= 4'd7) return 3;
        return 1;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Run one op; optionally inject a start with another op while busy.
    task automatic run_op(input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input bit inject);
        int cyc;
        logic [31:0] e;
        e = exp_res(op, a, b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 10) begin
            if (inject) begin
                start_i = 1'b1; op_i = 4'd4; a_i = ~a; b_i = 32'h1234_5678;
            end
            check(busy_o == 1'b1, "R8 busy in flight", 64'(busy_o), 64'd1);
            check(result_o == e, "R9 result held while busy", 64'(result_o), 64'(e));
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check(cyc == exp_lat(op), (op >= 4'd10) ? "R10 latency" : "R2 latency",
              64'(cyc), 64'(exp_lat(op)));
        check(result_o == e,
              (op <= 1) ? "R4 arith" : (op <= 4) ? "R5 logic" : (op <= 7) ? "R6 shift" :
              (op <= 9) ? "R7 compare" : "R10 unused op",
              64'(result_o), 64'(e));
        check(busy_o == 1'b1, "R8 busy in done cycle", 64'(busy_o), 64'd1);
        @(negedge clk);
        check(done_o == 1'b0, "R3 done one cycle", 64'(done_o), 64'd0);
        check(busy_o == 1'b0, "R9 no stray op after done", 64'(busy_o), 64'd0);
        check(result_o == e, "R3 result holds", 64'(result_o), 64'(e));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] vals [8];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h8000_0000;
        vals[4] = 32'h7FFF_FFFF; vals[5] = 32'hA5A5_0F3C;
        vals[6] = 32'h0000_0024; vals[7] = 32'h1234_5679;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(done_o == 0, "R11 done reset", 64'(done_o), 0);
        check(busy_o == 0, "R11 busy reset", 64'(busy_o), 0);
        check(result_o == 0, "R11 result reset", 64'(result_o), 0);
        rst_n = 1'b1;
        // R1 routing and main function over all opcodes and operand grid
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(4'(op), vals[i], vals[j], 1'b0);
        // R6 every shift amount, sign bit set
        for (int s = 0; s < 32; s++)
            for (int op = 5; op <= 7; op++)
                run_op(4'(op), 32'hC003_0F81, 32'(s) | 32'hFFFF_FFE0, 1'b0);
        // R9 starts injected while busy, for every class
        for (int op = 0; op < 16; op++)
            run_op(4'(op), 32'h8765_4321, 32'h0000_0007, 1'b1);
        // R3 back-to-back operations
        run_op(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0);
        run_op(4'd8, 32'hFFFF_FFFF, 32'd1, 1'b0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule